// File: doc/BRIEF.md
# Character Cell Pixel Generator for Text and Block Graphics

This block produces the single foreground bit for one pixel of a character cell on a text-mode display. Each clock, the surrounding display logic gives it the 7-bit character code of the cell under the beam, the pixel's row and column inside the cell, and the attribute state for that position: alphanumeric or block-graphics mode, joined or gapped blocks, and double height with a top or bottom half. It does not parse attributes and does not handle colour; it only decides whether the pixel is lit.

In block-graphics mode most codes are drawn as a 2-wide by 3-tall grid of blocks. Each block is lit by its own bit of the code, so no table is needed. Codes in the capital-letter range still come from the glyph table, which lets capitals sit among graphics without a mode change. The glyph table gives one whole glyph row per lookup, and a column index then picks the bit. Double height is made by halving the row index. For a bottom half, the cell height is added first.

The cell is 12 pixels wide by 20 rows. Each glyph dot covers 2x2 pixels of a 6x10 dot glyph. The result is registered, so it appears one clock after its inputs.

Top module: `ttx_cell_pixel`

## Requirements
- R1: While `rst` is high, and in the first cycle after a clock edge at which `rst` was high, `pix_o` is 0.
- R2: `pix_o` reflects the inputs sampled at the previous rising clock edge, one cycle of latency, and is held between edges.
- R3: In graphics mode (`gfx_i`=1), for codes 0x20-0x3F and 0x60-0x7F the cell is split into row bands 0-5, 6-13 and 14-19 and into column halves 0-5 and 6-11. The blocks map to code bits as follows: top-left bit0, top-right bit1, middle-left bit2, middle-right bit3, bottom-left bit4, bottom-right bit6. A pixel is 1 when its block's bit is 1.
- R4: With `sep_i`=1, a graphics block is blanked in the last two columns of its half (columns 4,5,10,11) and in the last two rows of its band (rows 4,5,12,13,18,19). With `sep_i`=0, blocks touch.
- R5: In graphics mode, codes 0x40-0x5F are drawn from the glyph table exactly as in alphanumeric mode, and `sep_i` has no effect on them.
- R6: In alphanumeric mode (`gfx_i`=0), every code 0x20-0x7F is drawn from the glyph table. Glyph row g = row/2 and glyph column k = col/2. The pixel is bit (5-k) of the glyph row pattern P. P is 0 for code 0x20, for g=0 and for g=9. For odd g, P equals code bits [5:0]. For even g in 2..8, P is code bits [5:0] rotated right by one, so bit0 moves to bit5.
- R7: Codes 0x00-0x1F give 0 in both modes.
- R8: With `dbl_i`=1, the row used for both glyphs and blocks is (row + 20*`dbl_bot_i`)/2. With `dbl_i`=0 it is the row itself, and `dbl_bot_i` has no effect.
- R9: A row above 19 or a column above 11 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 7 | Character code of the current cell |
| gfx_i | input | 1 | 1 = block-graphics mode, 0 = alphanumeric |
| sep_i | input | 1 | 1 = gapped blocks, 0 = joined blocks |
| dbl_i | input | 1 | Double-height enable |
| dbl_bot_i | input | 1 | Selects the lower half when double height is on |
| row_i | input | 5 | Pixel row inside the cell, 0-19 |
| col_i | input | 4 | Pixel column inside the cell, 0-11 |
| pix_o | output | 1 | Foreground pixel, registered |

## Verification
A wrong row band edge or bit mapping in the block path shows up as a whole strip of wrong pixels in the very next cycle. The bench therefore sweeps every block code over every row and column in both joined and gapped forms. A slip in the double-height arithmetic shifts glyph rows by one or more dots. It is visible only at the band edges, at glyph rows near the middle of the cell, and in the bottom half, so the random stimulus mixes double height into all code classes. Because the data path holds no state, each error appears at `pix_o` one cycle after the input that exposes it.

// File: rtl/ttx_cell_pkg.sv
package ttx_cell_pkg;

    localparam int CELL_W  = 12;
    localparam int CELL_H  = 20;
    localparam int SCALE   = 2;               // screen pixels per glyph dot
    localparam int GLYPH_W = CELL_W / SCALE;
    localparam int GLYPH_H = CELL_H / SCALE;
    localparam int GAP     = 2;               // gap width in gapped block mode
    localparam int ROW_W   = $clog2(CELL_H);
    localparam int COL_W   = $clog2(CELL_W);
    localparam int GROW_W  = $clog2(GLYPH_H);
    localparam int HALF_W  = CELL_W / 2;
    localparam int BAND0_END = (CELL_H * 3) / 10;
    localparam int BAND1_END = (CELL_H * 7) / 10;

    typedef enum logic [1:0] {
        SRC_BLANK  = 2'd0,
        SRC_GLYPH  = 2'd1,
        SRC_MOSAIC = 2'd2
    } src_e;

    typedef struct packed {
        logic [ROW_W-1:0]  eff_row;
        logic [GROW_W-1:0] glyph_row;
        logic [1:0]        band;
        logic              band_gap;
    } rowmap_t;

    // Procedural glyph table: one full dot row per lookup.
    function automatic logic [GLYPH_W-1:0] font_row(input logic [6:0] code,
                                                     input logic [GROW_W-1:0] grow);
        logic [GLYPH_W-1:0] base;
        base = code[GLYPH_W-1:0];
        if (code == 7'h20 || grow == '0 || grow == GROW_W'(GLYPH_H - 1))
            return '0;
        else if (grow[0])
            return base;
        else
            return {base[0], base[GLYPH_W-1:1]};
    endfunction

endpackage

// File: rtl/ttx_row_map.sv
module ttx_row_map
    import ttx_cell_pkg::*;
(
    input  logic [ROW_W-1:0] row_i,
    input  logic             dbl_i,
    input  logic             dbl_bot_i,
    output rowmap_t          map_o
);
    localparam logic [ROW_W:0]   HALF_OFS = (ROW_W+1)'(CELL_H);
    localparam logic [ROW_W-1:0] B0_END   = ROW_W'(BAND0_END);
    localparam logic [ROW_W-1:0] B1_END   = ROW_W'(BAND1_END);
    localparam logic [ROW_W-1:0] B0_GAP   = ROW_W'(BAND0_END - GAP);
    localparam logic [ROW_W-1:0] B1_GAP   = ROW_W'(BAND1_END - GAP);
    localparam logic [ROW_W-1:0] B2_GAP   = ROW_W'(CELL_H - GAP);

    logic [ROW_W:0]   shifted_sum;
    logic [ROW_W-1:0] eff;

    always_comb begin
        shifted_sum = {1'b0, row_i} + (dbl_bot_i ? HALF_OFS : '0);
        eff = dbl_i ? shifted_sum[ROW_W:1] : row_i;

        map_o.eff_row   = eff;
        map_o.glyph_row = eff[ROW_W-1:1];
        if (eff < B0_END) begin
            map_o.band     = 2'd0;
            map_o.band_gap = (eff >= B0_GAP);
        end else if (eff < B1_END) begin
            map_o.band     = 2'd1;
            map_o.band_gap = (eff >= B1_GAP);
        end else begin
            map_o.band     = 2'd2;
            map_o.band_gap = (eff >= B2_GAP);
        end
    end
endmodule

// File: rtl/ttx_mosaic.sv
module ttx_mosaic
    import ttx_cell_pkg::*;
(
    input  logic [6:0]       code_i,
    input  rowmap_t          map_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             sep_i,
    output logic             bit_o
);
    localparam logic [COL_W-1:0] HALF     = COL_W'(HALF_W);
    localparam logic [COL_W-1:0] HALF_GAP = COL_W'(HALF_W - GAP);

    logic             right;
    logic [COL_W-1:0] col_in_half;
    logic             col_gap;
    logic             block_on;

    always_comb begin
        right       = (col_i >= HALF);
        col_in_half = right ? (col_i - HALF) : col_i;
        col_gap     = (col_in_half >= HALF_GAP);
        unique case (map_i.band)
            2'd0:    block_on = right ? code_i[1] : code_i[0];
            2'd1:    block_on = right ? code_i[3] : code_i[2];
            default: block_on = right ? code_i[6] : code_i[4];
        endcase
        bit_o = block_on && !(sep_i && (col_gap || map_i.band_gap));
    end
endmodule

// File: rtl/ttx_glyph.sv
module ttx_glyph
    import ttx_cell_pkg::*;
(
    input  logic [6:0]        code_i,
    input  logic [GROW_W-1:0] glyph_row_i,
    input  logic [COL_W-1:0]  col_i,
    output logic              bit_o
);
    localparam int GCOL_W = $clog2(GLYPH_W);

    logic [GLYPH_W-1:0] row_bits;
    logic [GCOL_W-1:0]  gcol;

    always_comb begin
        row_bits = font_row(code_i, glyph_row_i);
        gcol     = GCOL_W'(col_i >> 1);
        bit_o    = row_bits[GCOL_W'(GLYPH_W - 1) - gcol];
    end
endmodule

// File: rtl/ttx_cell_pixel.sv
module ttx_cell_pixel
    import ttx_cell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [6:0]       code_i,
    input  logic             gfx_i,
    input  logic             sep_i,
    input  logic             dbl_i,
    input  logic             dbl_bot_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    output logic             pix_o
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(CELL_H - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(CELL_W - 1);

    rowmap_t rmap;
    logic    mosaic_bit;
    logic    glyph_bit;
    src_e    src;
    logic    pix_d;

    ttx_row_map u_row_map (
        .row_i     (row_i),
        .dbl_i     (dbl_i),
        .dbl_bot_i (dbl_bot_i),
        .map_o     (rmap)
    );

    ttx_mosaic u_mosaic (
        .code_i (code_i),
        .map_i  (rmap),
        .col_i  (col_i),
        .sep_i  (sep_i),
        .bit_o  (mosaic_bit)
    );

    ttx_glyph u_glyph (
        .code_i      (code_i),
        .glyph_row_i (rmap.glyph_row),
        .col_i       (col_i),
        .bit_o       (glyph_bit)
    );

    always_comb begin
        if (code_i[6:5] == 2'b00 || row_i > ROW_LAST || col_i > COL_LAST)
            src = SRC_BLANK;
        else if (gfx_i && code_i[6:5] != 2'b10)
            src = SRC_MOSAIC;
        else
            src = SRC_GLYPH;

        unique case (src)
            SRC_MOSAIC: pix_d = mosaic_bit;
            SRC_GLYPH:  pix_d = glyph_bit;
            default:    pix_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pix_o <= 1'b0;
        else     pix_o <= pix_d;
    end

    // R1: reset clears the output one edge later
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> !pix_o);

    // R7: control-range codes never light a pixel
    a_r7_ctrl_blank: assert property (@(posedge clk) disable iff (rst)
        (code_i < 7'h20) |=> !pix_o);

    // R9: positions outside the cell are dark
    a_r9_range_blank: assert property (@(posedge clk) disable iff (rst)
        (row_i > ROW_LAST || col_i > COL_LAST) |=> !pix_o);

    // R4: gapped blocks leave their gap columns dark
    a_r4_sep_col_gap: assert property (@(posedge clk) disable iff (rst)
        (gfx_i && sep_i && code_i[6:5] != 2'b00 && code_i[6:5] != 2'b10 &&
         (col_i == 4'd4 || col_i == 4'd5 || col_i == 4'd10 || col_i == 4'd11))
        |=> !pix_o);

    // R3: an all-blocks code lights every in-cell pixel when joined
    a_r3_full_block: assert property (@(posedge clk) disable iff (rst)
        (gfx_i && !sep_i && code_i == 7'h7F && row_i <= ROW_LAST && col_i <= COL_LAST)
        |=> pix_o);

endmodule

// File: tb/ttx_cell_pixel_tb_top.sv
`timescale 1ns/1ps
module ttx_cell_pixel_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] code = '0;
    logic       gfx = 1'b0, sep = 1'b0, dbl = 1'b0, bot = 1'b0;
    logic [4:0] row = '0;
    logic [3:0] col = '0;
    logic       pix;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    ttx_cell_pixel dut_i (
        .clk(clk), .rst(rst), .code_i(code), .gfx_i(gfx), .sep_i(sep),
        .dbl_i(dbl), .dbl_bot_i(bot), .row_i(row), .col_i(col), .pix_o(pix)
    );

    // Expected glyph dot from R6
    function automatic bit exp_glyph(int c, int r_eff, int cl);
        int g, p;
        g = r_eff / 2;
        if (c == 32 || g == 0 || g == 9) return 1'b0;
        if (g % 2 == 1) p = c % 64;
        else            p = ((c % 2) * 32) + ((c % 64) / 2);
        return ((p >> (5 - cl / 2)) & 1) == 1;
    endfunction

    // Expected pixel from R3..R9
    function automatic bit exp_pix(int c, bit g, bit s, bit d, bit b, int r, int cl);
        int re, band, bitn;
        bit rgt;
        if (c < 32 || r > 19 || cl > 11) return 1'b0;
        re = d ? (r + (b ? 20 : 0)) / 2 : r;
        if (!g || (c >= 64 && c < 96)) return exp_glyph(c, re, cl);
        band = (re < 6) ? 0 : (re < 14) ? 1 : 2;
        rgt  = cl >= 6;
        bitn = (band == 0) ? (rgt ? 1 : 0) : (band == 1) ? (rgt ? 3 : 2) : (rgt ? 6 : 4);
        if (s) begin
            if ((cl % 6) >= 4) return 1'b0;
            if (re == 4 || re == 5 || re == 12 || re == 13 || re == 18 || re == 19) return 1'b0;
        end
        return ((c >> bitn) & 1) == 1;
    endfunction

    function automatic string tag_of(int c, bit g, bit s, bit d, int r, int cl);
        if (c < 32)                       return "R7";
        if (r > 19 || cl > 11)            return "R9";
        if (d)                            return "R8";
        if (!g)                           return "R6";
        if (c >= 64 && c < 96)            return "R5";
        if (s)                            return "R4";
        return "R3";
    endfunction

    task automatic check(string tag, bit expv);
        n_checks++;
        if (pix !== expv) begin
            n_fail++;
            $display("FAIL %s code=%h gfx=%0b sep=%0b dbl=%0b bot=%0b row=%0d col=%0d actual=%0b expected=%0b",
                     tag, code, gfx, sep, dbl, bot, row, col, pix, expv);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (R2 latency).
    task automatic apply(int c, bit g, bit s, bit d, bit b, int r, int cl);
        code = 7'(c); gfx = g; sep = s; dbl = d; bot = b; row = 5'(r); col = 4'(cl);
        @(negedge clk);
        check(tag_of(c, g, s, d, r, cl), exp_pix(c, g, s, d, b, r, cl));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        // R1: reset dominates a pattern that would light the pixel
        code = 7'h7F; gfx = 1'b1; row = 5'd0; col = 4'd0;
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst = 1'b0;

        // R2: output keeps old value until the edge, then follows
        apply(7'h00, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
        code = 7'h7F; gfx = 1'b1; sep = 1'b0; row = 5'd3; col = 4'd2;
        #1 check("R2", 1'b0);
        @(negedge clk);
        check("R2", 1'b1);

        // R3/R4: every block code, every position, joined and gapped
        for (int s = 0; s < 2; s++)
            for (int c = 32; c < 128; c++) begin
                if (c >= 64 && c < 96) continue;
                for (int r = 0; r < 20; r++)
                    for (int cl = 0; cl < 12; cl++)
                        apply(c, 1'b1, s[0], 1'b0, 1'b0, r, cl);
            end

        // R5: capitals in graphics mode, gapped setting ignored
        for (int c = 64; c < 96; c++)
            for (int r = 0; r < 20; r++)
                apply(c, 1'b1, 1'b1, 1'b0, 1'b0, r, (c + r) % 12);

        // R6: alphanumeric, incl. blank space code
        for (int r = 0; r < 20; r++)
            for (int cl = 0; cl < 12; cl++) begin
                apply(7'h20, 1'b0, 1'b0, 1'b0, 1'b0, r, cl);
                apply(7'h6B, 1'b0, 1'b0, 1'b0, 1'b0, r, cl);
            end

        // R7: control codes in both modes
        for (int c = 0; c < 32; c++) begin
            apply(c, 1'b1, 1'b0, 1'b0, 1'b0, 8, 1);
            apply(c, 1'b0, 1'b0, 1'b0, 1'b0, 8, 1);
        end

        // R8: double height top and bottom, glyph and block; bot ignored when dbl=0
        for (int r = 0; r < 20; r++)
            for (int cl = 0; cl < 12; cl++) begin
                apply(7'h41, 1'b0, 1'b0, 1'b1, 1'b0, r, cl);
                apply(7'h41, 1'b0, 1'b0, 1'b1, 1'b1, r, cl);
                apply(7'h35, 1'b1, 1'b1, 1'b1, 1'b1, r, cl);
                apply(7'h6A, 1'b1, 1'b0, 1'b0, 1'b1, r, cl);
            end

        // R9: out-of-range positions
        apply(7'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 20, 0);
        apply(7'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 31, 5);
        apply(7'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 3, 12);
        apply(7'h55, 1'b0, 1'b0, 1'b1, 1'b1, 25, 15);

        // Random mix across all inputs
        for (int i = 0; i < 20000; i++) begin
            int c, r, cl;
            c  = int'($urandom % 128);
            r  = ($urandom % 16 == 0) ? int'($urandom % 32) : int'($urandom % 20);
            cl = ($urandom % 16 == 0) ? int'($urandom % 16) : int'($urandom % 12);
            apply(c, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), r, cl);
        end

        // R1: reset mid-run clears the output
        apply(7'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);
        rst = 1'b0;

        finish_run();
    end

endmodule